// File: doc/BRIEF.md
# Incrementing-Pattern Block Checker and Ramp Generator

This block checks whether a set of read and write timing settings moves a data block through memory without corruption. For the write phase, a ramp generator emits a run of 16-bit words from a programmed seed. Each word is one greater than the word before it, wrapping modulo 2^16. The run advances only when the downstream side is ready.

For the read phase, the checker takes the words read back from a region that lies inside the recorded block. The words arrive in bursts of eight. The checker ignores the first and last bursts, because settings that are still wrong can corrupt those bursts.

The checker compares each retained word against the retained word before it. It does not need the base address of the region or the starting data value. Any break in the ramp is counted as an error. When the read is declared finished, the checker reports a pass flag, a saturating error count and the stream position of the first bad word.

Top module: `ramp_verifier`

## Requirements
- R1: After reset, errCount, firstErrIdx, pass, resultValid and genValid are all 0.
- R2: The read stream is grouped into bursts of 8 words that count up from the start pulse. The burst count sampled at start is N. Only words in bursts 1 to N-2 (numbered from 0) are retained. Words in burst 0, in burst N-1 and in any later burst never change errCount.
- R3: The first retained word after start only seeds the comparison and never counts as an error.
- R4: Each later retained word counts one error when it differs from the previous retained word plus one, modulo 2^16. The received word, whether it is right or wrong, becomes the new previous word.
- R5: errCount is 8 bits wide and saturates at 255.
- R6: firstErrIdx is the 0-based position of the first mismatching word in the read stream, counting every valid word since start and including skipped words. It keeps that value through later errors and reads 0 while there are no errors.
- R7: A cycle with rdEnd high makes resultValid high for one cycle in the next cycle. At that point pass is 1 only if errCount is 0 and at least one comparison was made. pass holds its value until the next start.
- R8: A start pulse clears errCount, firstErrIdx and pass, and restarts burst numbering. A word presented in the same cycle as start is ignored.
- R9: After genStart, the generator presents genValid with genData equal to seed, then seed+1 and so on, wrapping modulo 2^16. It advances only on a cycle with genReady high and holds genData while genReady is low. It delivers exactly genCount words, after which genValid is 0. A count of 0 delivers nothing.
- R10: When N is below 3 no word is retained, so pass reads 0 at the end of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new read check and samples numBursts |
| numBursts | input | 10 | Number of bursts in the readback |
| rdValid | input | 1 | Read word valid |
| rdData | input | 16 | Read word |
| rdEnd | input | 1 | End of the read; requests the result |
| errCount | output | 8 | Saturating mismatch count |
| firstErrIdx | output | 10 | Stream position of the first mismatch |
| pass | output | 1 | Verdict of the last finished read |
| resultValid | output | 1 | One-cycle pulse when the verdict is updated |
| genStart | input | 1 | Loads seed and word count into the generator |
| genSeed | input | 16 | First word of the ramp |
| genCount | input | 10 | Number of words to emit |
| genReady | input | 1 | Downstream accepts the current word |
| genValid | output | 1 | Generator word valid |
| genData | output | 16 | Generator word |

## Verification
The assertions check the following on every cycle:
- errCount never moves when no word arrives, and otherwise rises by at most one per cycle.
- errCount stays at its ceiling once it has reached it.
- firstErrIdx is frozen once an error has been counted.
- A start clears the result.
- A passing verdict is never issued with errors on the counter.
- The generator holds its word while it is stalled.

Only the bench scenarios can show which words are actually retained, because that depends on burst position. The same holds for seeding, for the exact error totals and first-error positions of clean, corrupted, wrapping and fully random streams, and for the exact word sequence and length that the generator delivers.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic clear;   // new read check begins
    logic keep;    // current word is retained
    logic seed;    // current word is the first retained word
    logic finish;  // produce the verdict
  } ctrlStrobes_t;
endpackage

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import ramp_pkg::*;
#(
  parameter int BURST_LEN = 8,
  parameter int IDX_W     = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] numBursts,
  input  logic             rdValid,
  input  logic             rdEnd,
  output ctrlStrobes_t     strobes,
  output logic [IDX_W-1:0] curIdx
);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic [BEAT_W-1:0] beat;
  logic [IDX_W-1:0]  burstNum;
  logic [IDX_W-1:0]  totalBursts;
  logic [IDX_W-1:0]  wordIdx;
  logic              seeded;
  logic              inMiddle;

  // A word is retained when its burst is neither the first nor the last (or later)
  always_comb begin
    inMiddle = (burstNum != '0) &&
               (({1'b0, burstNum} + (IDX_W+1)'(1)) < {1'b0, totalBursts});
    strobes.clear  = start;
    strobes.keep   = rdValid && !start && inMiddle;
    strobes.seed   = strobes.keep && !seeded;
    strobes.finish = rdEnd && !start;
    curIdx         = wordIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beat        <= '0;
      burstNum    <= '0;
      totalBursts <= '0;
      wordIdx     <= '0;
      seeded      <= 1'b0;
    end else if (start) begin
      beat        <= '0;
      burstNum    <= '0;
      totalBursts <= numBursts;
      wordIdx     <= '0;
      seeded      <= 1'b0;
    end else if (rdValid) begin
      wordIdx <= wordIdx + 1'b1;
      if (strobes.keep) seeded <= 1'b1;
      if (beat == LAST_BEAT) begin
        beat <= '0;
        if (burstNum != '1) burstNum <= burstNum + 1'b1;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ramp_datapath.sv
module ramp_datapath
  import ramp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 10,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [IDX_W-1:0]  curIdx,
  input  logic [WORD_W-1:0] rdData,
  output logic [ERR_W-1:0]  errCount,
  output logic [IDX_W-1:0]  firstErrIdx,
  output logic              pass,
  output logic              resultValid
);
  logic [WORD_W-1:0] prevWord;
  logic [WORD_W-1:0] expWord;
  logic              compared;
  logic              mismatch;

  always_comb begin
    expWord  = prevWord + 1'b1;
    mismatch = strobes.keep && !strobes.seed && (rdData != expWord);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWord    <= '0;
      errCount    <= '0;
      firstErrIdx <= '0;
      compared    <= 1'b0;
      pass        <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strobes.finish;
      if (strobes.clear) begin
        errCount    <= '0;
        firstErrIdx <= '0;
        compared    <= 1'b0;
        pass        <= 1'b0;
      end else begin
        if (strobes.keep) begin
          prevWord <= rdData;
          if (!strobes.seed) compared <= 1'b1;
        end
        if (mismatch) begin
          if (errCount == '0) firstErrIdx <= curIdx;
          if (errCount != '1) errCount <= errCount + 1'b1;
        end
        if (strobes.finish) pass <= (errCount == '0) && compared;
      end
    end
  end
endmodule

// File: rtl/ramp_gen.sv
module ramp_gen #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              genStart,
  input  logic [WORD_W-1:0] genSeed,
  input  logic [CNT_W-1:0]  genCount,
  input  logic              genReady,
  output logic              genValid,
  output logic [WORD_W-1:0] genData
);
  logic [CNT_W-1:0] remaining;

  assign genValid = (remaining != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genData   <= '0;
      remaining <= '0;
    end else if (genStart) begin
      genData   <= genSeed;
      remaining <= genCount;
    end else if (genValid && genReady) begin
      genData   <= genData + 1'b1;
      remaining <= remaining - 1'b1;
    end
  end
endmodule

// File: rtl/ramp_verifier.sv
module ramp_verifier
  import ramp_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int BURST_LEN = 8,
  parameter int IDX_W     = 10,
  parameter int ERR_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [IDX_W-1:0]  numBursts,
  input  logic              rdValid,
  input  logic [WORD_W-1:0] rdData,
  input  logic              rdEnd,
  output logic [ERR_W-1:0]  errCount,
  output logic [IDX_W-1:0]  firstErrIdx,
  output logic              pass,
  output logic              resultValid,
  input  logic              genStart,
  input  logic [WORD_W-1:0] genSeed,
  input  logic [IDX_W-1:0]  genCount,
  input  logic              genReady,
  output logic              genValid,
  output logic [WORD_W-1:0] genData
);
  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] curIdx;

  ramp_ctrl #(.BURST_LEN(BURST_LEN), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .numBursts(numBursts),
    .rdValid(rdValid), .rdEnd(rdEnd), .strobes(strobes), .curIdx(curIdx)
  );

  ramp_datapath #(.WORD_W(WORD_W), .IDX_W(IDX_W), .ERR_W(ERR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curIdx(curIdx),
    .rdData(rdData), .errCount(errCount), .firstErrIdx(firstErrIdx),
    .pass(pass), .resultValid(resultValid)
  );

  ramp_gen #(.WORD_W(WORD_W), .CNT_W(IDX_W)) gen_i (
    .clk(clk), .rstN(rstN), .genStart(genStart), .genSeed(genSeed),
    .genCount(genCount), .genReady(genReady), .genValid(genValid),
    .genData(genData)
  );
endmodule

// File: rtl/ramp_verifier_chk.sv
module ramp_verifier_chk #(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 10,
  parameter int ERR_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              rdValid,
  input logic [ERR_W-1:0]  errCount,
  input logic [IDX_W-1:0]  firstErrIdx,
  input logic              pass,
  input logic              resultValid,
  input logic              genStart,
  input logic              genReady,
  input logic              genValid,
  input logic [WORD_W-1:0] genData
);
  // R4: the count moves only when a word arrives
  a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!rdValid && !start) |=> $stable(errCount));

  // R4: at most one error per word
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (!start) |=> (errCount == $past(errCount) || errCount == $past(errCount) + 1'b1));

  // R5: saturation
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (errCount == '1 && !start) |=> errCount == '1);

  // R6: first-error position frozen once an error exists
  a_r6_first_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (errCount != '0 && !start) |=> $stable(firstErrIdx));

  // R7: a pass verdict never comes with errors
  a_r7_pass_clean: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && pass) |-> errCount == '0);

  // R8: start clears the result
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (errCount == '0 && firstErrIdx == '0 && !pass));

  // R9: stalled generator holds its word
  a_r9_gen_hold: assert property (@(posedge clk) disable iff (!rstN)
    (genValid && !genReady && !genStart) |=> (genValid && $stable(genData)));
endmodule

bind ramp_verifier ramp_verifier_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W), .ERR_W(ERR_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .rdValid(rdValid),
  .errCount(errCount), .firstErrIdx(firstErrIdx), .pass(pass),
  .resultValid(resultValid), .genStart(genStart), .genReady(genReady),
  .genValid(genValid), .genData(genData)
);

// File: tb/ramp_verifier_tb.sv
module ramp_verifier_tb_top;
  localparam int CLK_HALF = 10;  // 50 MHz

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  numBursts = '0;
  logic        rdValid = 1'b0;
  logic [15:0] rdData = '0;
  logic        rdEnd = 1'b0;
  logic [7:0]  errCount;
  logic [9:0]  firstErrIdx;
  logic        pass;
  logic        resultValid;
  logic        genStart = 1'b0;
  logic [15:0] genSeed = '0;
  logic [9:0]  genCount = '0;
  logic        genReady = 1'b0;
  logic        genValid;
  logic [15:0] genData;

  int checks = 0;
  int fails  = 0;
  logic [15:0] stream [0:511];

  always #CLK_HALF clk = ~clk;

  ramp_verifier dut_i (
    .clk(clk), .rstN(rstN), .start(start), .numBursts(numBursts),
    .rdValid(rdValid), .rdData(rdData), .rdEnd(rdEnd),
    .errCount(errCount), .firstErrIdx(firstErrIdx), .pass(pass),
    .resultValid(resultValid), .genStart(genStart), .genSeed(genSeed),
    .genCount(genCount), .genReady(genReady), .genValid(genValid),
    .genData(genData)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Run one read check over stream[0:n-1] and compare with values derived from R2..R7, R10
  task automatic runRead(input int nb, input int n, input int gapPct, input string tag);
    int expErr = 0;
    int expIdx = 0;
    bit have = 0;
    bit cmp = 0;
    logic [15:0] prev = '0;
    for (int i = 0; i < n; i++) begin
      int b = i / 8;
      if (b >= 1 && b < nb - 1) begin  // R2: edge bursts skipped
        if (have) begin                // R3: first retained only seeds
          cmp = 1;
          if (stream[i] != 16'(prev + 16'd1)) begin  // R4
            if (expErr == 0) expIdx = i % 1024;      // R6
            if (expErr < 255) expErr++;              // R5
          end
        end
        prev = stream[i];
        have = 1;
      end
    end
    @(negedge clk);
    start = 1'b1; numBursts = 10'(nb);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      while (($urandom % 100) < gapPct) begin
        rdValid = 1'b0;
        @(negedge clk);
      end
      rdValid = 1'b1; rdData = stream[i];
      @(negedge clk);
    end
    rdValid = 1'b0;
    rdEnd = 1'b1;
    @(negedge clk);
    rdEnd = 1'b0;
    chk({tag, " R7 resultValid"}, int'(resultValid), 1);
    chk({tag, " R4 R5 errCount"}, int'(errCount), expErr);
    chk({tag, " R6 firstErrIdx"}, int'(firstErrIdx), expIdx);
    chk({tag, " R7 pass"}, int'(pass), (expErr == 0 && cmp) ? 1 : 0);
    @(negedge clk);
    chk({tag, " R7 one-cycle pulse"}, int'(resultValid), 0);
  endtask

  task automatic fillRamp(input int n, input logic [15:0] base);
    for (int i = 0; i < n; i++) stream[i] = 16'(base + 16'(i));
  endtask

  task automatic runGen(input logic [15:0] seed, input int cnt, input int readyPct);
    int got = 0;
    @(negedge clk);
    genStart = 1'b1; genSeed = seed; genCount = 10'(cnt);
    @(negedge clk);
    genStart = 1'b0;
    for (int cyc = 0; cyc < 4 * cnt + 20 && got < cnt; cyc++) begin
      genReady = (($urandom % 100) < readyPct);
      if (genValid && genReady) begin
        chk("R9 gen word", int'(genData), int'(16'(seed + 16'(got))));
        got++;
      end
      @(negedge clk);
    end
    genReady = 1'b0;
    chk("R9 gen word total", got, cnt);
    chk("R9 genValid low after run", int'(genValid), 0);
  endtask

  initial begin
    #(CLK_HALF * 2 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 errCount", int'(errCount), 0);
    chk("R1 firstErrIdx", int'(firstErrIdx), 0);
    chk("R1 pass", int'(pass), 0);
    chk("R1 resultValid", int'(resultValid), 0);
    chk("R1 genValid", int'(genValid), 0);
    rstN = 1'b1;

    // R9 generator: wrap, stalls, zero count
    runGen(16'hFFFC, 9, 60);
    runGen(16'h1234, 20, 100);
    runGen(16'h0000, 0, 100);

    // R2 R3: clean ramp, garbage edge bursts
    fillRamp(40, 16'h5000);
    for (int i = 0; i < 8; i++) stream[i] = 16'($urandom);
    for (int i = 32; i < 40; i++) stream[i] = 16'($urandom);
    runRead(5, 40, 30, "clean");

    // R4 wrap across 2^16 inside retained region
    fillRamp(48, 16'hFFE0);
    runRead(6, 48, 0, "wrap");

    // R4 R6: single corrupted word in the middle
    fillRamp(48, 16'h0100);
    stream[21] = stream[21] ^ 16'h0040;
    runRead(6, 48, 20, "corrupt-mid");

    // R4: corrupted last retained word yields one error
    fillRamp(32, 16'h0700);
    stream[23] = 16'hDEAD;
    runRead(4, 32, 0, "corrupt-last");

    // R2: words beyond the declared bursts ignored
    fillRamp(24, 16'h3000);
    for (int i = 24; i < 56; i++) stream[i] = 16'($urandom);
    runRead(3, 56, 10, "overrun");

    // R10: too few bursts
    fillRamp(16, 16'h0001);
    runRead(2, 16, 0, "two-bursts");

    // R5: saturation with random data
    for (int i = 0; i < 320; i++) stream[i] = 16'($urandom);
    runRead(40, 320, 5, "saturate");

    // R8: start clears, same-cycle word ignored
    @(negedge clk);
    start = 1'b1; numBursts = 10'd4; rdValid = 1'b1; rdData = 16'hBEEF;
    @(negedge clk);
    start = 1'b0; rdValid = 1'b0;
    chk("R8 errCount cleared", int'(errCount), 0);
    chk("R8 pass cleared", int'(pass), 0);
    chk("R8 firstErrIdx cleared", int'(firstErrIdx), 0);

    // Random mix of ramps with random corruptions
    for (int t = 0; t < 8; t++) begin
      int nb = 3 + int'($urandom % 10);
      int n = nb * 8;
      fillRamp(n, 16'($urandom));
      if ($urandom % 2) stream[$urandom % n] = 16'($urandom);
      runRead(nb, n, 25, "random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule